// File: doc/BRIEF.md
# Link Speed Downshift Sequencer

This block decides which line rate a tri-speed Ethernet transceiver should try next while it looks for a link. Every search starts at gigabit. When automatic downshift is enabled and an attempt fails, the next attempt drops to 100 Mb/s, and after that to 10 Mb/s. A failure at 10 Mb/s wraps the search back to gigabit, and the cycle repeats for as long as no link forms. With downshift disabled, every attempt targets gigabit and no downshift is ever reported.

Once a link has formed at any rate, the block holds that rate. When that link is later lost, the search restarts at gigabit. Each entry into an attempt produces a one-cycle start pulse for the negotiation logic. Each step down in rate produces a one-cycle event. A mask input lets that event through to an interrupt request output.

States:
- IDLE: the reset state.
- TRY_G, TRY_F and TRY_T: attempts at 1000, 100 and 10 Mb/s.
- UP_G, UP_F and UP_T: a link has been established at that rate.

Transitions:
- Start-up: IDLE goes to TRY_G.
- Step-down: a failure in TRY_G goes to TRY_F, and a failure in TRY_F goes to TRY_T (enable set).
- Wrap: a failure in TRY_T goes to TRY_G (enable set).
- Retry-top: a failure in any TRY state goes to TRY_G (enable clear).
- Link-formed: TRY_x goes to UP_x.
- Link-lost: UP_x goes to TRY_G.

Top module: `link_downshift_seq`

## Requirements
- R1: While reset is held, and in the first sample after it, the block is in IDLE. `spd_sel` reads 2'b10, and `try_start`, `dshift_evt` and `dshift_irq` are 0.
- R2: On the first clock edge after reset is released, the block enters TRY_G. `try_start` is 1 for that cycle.
- R3: With `dshift_en`=1, a `try_fail` in TRY_G moves to the 100 Mb/s attempt and a `try_fail` in TRY_F moves to the 10 Mb/s attempt. Each of these steps sets `dshift_evt` for one cycle.
- R4: With `dshift_en`=1, a `try_fail` in TRY_T moves to TRY_G. That step pulses `try_start` and leaves `dshift_evt` at 0.
- R5: With `dshift_en`=0, a `try_fail` in any attempt moves to TRY_G and never sets `dshift_evt`.
- R6: A `link_up` during an attempt moves to the matching UP state. `spd_sel` stays unchanged and no start pulse is issued.
- R7: A `link_lost` in any UP state moves to TRY_G, with a `try_start` pulse and no event.
- R8: `try_start` is 1 for exactly the cycle after each entry into a TRY state, and 0 at all other times.
- R9: `dshift_irq` is 1 exactly in the cycles where `dshift_evt` is 1 and `evt_mask` was 1 at the edge that raised the event.
- R10: When `link_up` and `try_fail` arrive in the same cycle of an attempt, `link_up` wins.
- R11: `link_lost` has no effect during an attempt. `link_up` and `try_fail` have no effect in an UP state.
- R12: `spd_sel` encodes the targeted rate as 2'b10 for 1000 Mb/s, 2'b01 for 100 Mb/s and 2'b00 for 10 Mb/s. This encoding holds in both attempt and UP states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dshift_en | input | 1 | Enables automatic downshift |
| link_up | input | 1 | Strobe: the current attempt formed a link |
| try_fail | input | 1 | Strobe: the current attempt failed |
| link_lost | input | 1 | Strobe: the established link dropped |
| evt_mask | input | 1 | Lets downshift events through to the interrupt request |
| spd_sel | output | 2 | Targeted rate (10=1000, 01=100, 00=10 Mb/s) |
| try_start | output | 1 | One-cycle pulse on entry to each attempt |
| dshift_evt | output | 1 | One-cycle pulse on each step down in rate |
| dshift_irq | output | 1 | Masked downshift event |

## Verification
A corrupted state register shows up on the first sample after the edge that corrupts it. The fault appears as a wrong `spd_sel` value, or as a missing or extra `try_start` pulse on the next failure or link loss. A bad step-down or wrap decision appears one cycle after the failing attempt, as a wrong rate together with a wrong `dshift_evt`. A wrong UP/TRY distinction appears only when the next strobe is ignored or wrongly obeyed, so the bench applies every strobe combination in every state.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    localparam int SPD_W = 2;

    localparam logic [SPD_W-1:0] SPD_GIG  = 2'b10;
    localparam logic [SPD_W-1:0] SPD_FAST = 2'b01;
    localparam logic [SPD_W-1:0] SPD_TEN  = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TRY_G = 3'd1,
        ST_TRY_F = 3'd2,
        ST_TRY_T = 3'd3,
        ST_UP_G  = 3'd4,
        ST_UP_F  = 3'd5,
        ST_UP_T  = 3'd6
    } dsq_state_e;

    // Attempt state -> established state at the same rate
    function automatic dsq_state_e up_of(input dsq_state_e s);
        case (s)
            ST_TRY_F: return ST_UP_F;
            ST_TRY_T: return ST_UP_T;
            default:  return ST_UP_G;
        endcase
    endfunction

    // Next attempt after a failure with downshift enabled (wraps at the bottom)
    function automatic dsq_state_e lower_of(input dsq_state_e s);
        case (s)
            ST_TRY_G: return ST_TRY_F;
            ST_TRY_F: return ST_TRY_T;
            default:  return ST_TRY_G;
        endcase
    endfunction

    function automatic logic [SPD_W-1:0] spd_of(input dsq_state_e s);
        case (s)
            ST_TRY_F, ST_UP_F: return SPD_FAST;
            ST_TRY_T, ST_UP_T: return SPD_TEN;
            default:           return SPD_GIG;
        endcase
    endfunction

    function automatic logic is_up(input dsq_state_e s);
        return (s == ST_UP_G) || (s == ST_UP_F) || (s == ST_UP_T);
    endfunction

endpackage

// File: rtl/dsq_fsm.sv
module dsq_fsm
    import dsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dshift_en,
    input  logic       link_up,
    input  logic       try_fail,
    input  logic       link_lost,
    output dsq_state_e state_q,
    output logic       enter_try,
    output logic       step_down
);

    dsq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        enter_try = 1'b0;
        step_down = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d   = ST_TRY_G;
                enter_try = 1'b1;
            end
            ST_TRY_G, ST_TRY_F, ST_TRY_T: begin
                if (link_up) begin
                    state_d = up_of(state_q);
                end else if (try_fail) begin
                    enter_try = 1'b1;
                    if (dshift_en) begin
                        state_d   = lower_of(state_q);
                        step_down = (state_q != ST_TRY_T);
                    end else begin
                        state_d = ST_TRY_G;
                    end
                end
            end
            ST_UP_G, ST_UP_F, ST_UP_T: begin
                if (link_lost) begin
                    state_d   = ST_TRY_G;
                    enter_try = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // A step down never lands on the top rate
    AST_STEP_NOT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        step_down |=> (state_q == ST_TRY_F || state_q == ST_TRY_T)); // R3

    // A dropped link always restarts at gigabit
    AST_LOST_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_up(state_q) && link_lost) |=> (state_q == ST_TRY_G)); // R7

endmodule

// File: rtl/dsq_out.sv
module dsq_out
    import dsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  dsq_state_e       state_q,
    input  logic             enter_try,
    input  logic             step_down,
    input  logic             evt_mask,
    output logic [SPD_W-1:0] spd_sel,
    output logic             try_start,
    output logic             dshift_evt,
    output logic             dshift_irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            try_start  <= 1'b0;
            dshift_evt <= 1'b0;
            dshift_irq <= 1'b0;
        end else begin
            try_start  <= enter_try;
            dshift_evt <= step_down;
            dshift_irq <= step_down & evt_mask;
        end
    end

    always_comb spd_sel = spd_of(state_q);

    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        dshift_irq |-> dshift_evt); // R9

endmodule

// File: rtl/link_downshift_seq.sv
module link_downshift_seq
    import dsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dshift_en,
    input  logic             link_up,
    input  logic             try_fail,
    input  logic             link_lost,
    input  logic             evt_mask,
    output logic [SPD_W-1:0] spd_sel,
    output logic             try_start,
    output logic             dshift_evt,
    output logic             dshift_irq
);

    dsq_state_e state_q;
    logic       enter_try;
    logic       step_down;

    dsq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dshift_en (dshift_en),
        .link_up   (link_up),
        .try_fail  (try_fail),
        .link_lost (link_lost),
        .state_q   (state_q),
        .enter_try (enter_try),
        .step_down (step_down)
    );

    dsq_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .enter_try  (enter_try),
        .step_down  (step_down),
        .evt_mask   (evt_mask),
        .spd_sel    (spd_sel),
        .try_start  (try_start),
        .dshift_evt (dshift_evt),
        .dshift_irq (dshift_irq)
    );

    logic up_now;
    always_comb up_now = is_up(state_q);

    AST_EVT_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        dshift_evt |-> try_start); // R3

    AST_NOEN_NOEVT: assert property (@(posedge clk) disable iff (!rst_n)
        !dshift_en |=> !dshift_evt); // R5

    AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_now && $past(up_now)) |-> $stable(spd_sel)); // R6

    AST_NO_START_IN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        up_now |-> !try_start); // R8

endmodule

// File: tb/link_downshift_seq_bench.sv
module link_downshift_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dshift_en = 1'b0, link_up = 1'b0, try_fail = 1'b0;
    logic       link_lost = 1'b0, evt_mask = 1'b0;
    logic [1:0] spd_sel;
    logic       try_start, dshift_evt, dshift_irq;

    always #4 clk = ~clk;

    link_downshift_seq u_link_downshift_seq (
        .clk(clk), .rst_n(rst_n), .dshift_en(dshift_en), .link_up(link_up),
        .try_fail(try_fail), .link_lost(link_lost), .evt_mask(evt_mask),
        .spd_sel(spd_sel), .try_start(try_start), .dshift_evt(dshift_evt),
        .dshift_irq(dshift_irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference: idx 0=1000, 1=100, 2=10; rate code = 2 - idx
    bit m_idle, m_up;
    int m_idx;
    bit e_start, e_evt, e_irq;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit en, input bit up, input bit fl, input bit lo, input bit mk);
        string tag;
        dshift_en = en; link_up = up; try_fail = fl; link_lost = lo; evt_mask = mk;
        e_start = 0; e_evt = 0;
        if (m_idle) begin
            tag = "R2"; m_idle = 0; m_idx = 0; e_start = 1;
        end else if (!m_up) begin
            if (up && fl)      tag = "R10";
            else if (up)       tag = "R6";
            else if (fl && !en) tag = "R5";
            else if (fl && m_idx == 2) tag = "R4";
            else if (fl)       tag = "R3";
            else if (lo)       tag = "R11";
            else               tag = "R8";
            if (up) m_up = 1;
            else if (fl) begin
                e_start = 1;
                if (en) begin
                    m_idx = (m_idx + 1) % 3;
                    e_evt = (m_idx != 0);
                end else m_idx = 0;
            end
        end else begin
            if (lo) begin
                tag = "R7"; m_up = 0; m_idx = 0; e_start = 1;
            end else tag = (up || fl) ? "R11" : "R8";
        end
        e_irq = e_evt & mk;
        @(posedge clk);
        @(negedge clk);
        chk(tag, spd_sel, 2 - m_idx, "spd_sel (R12)");
        chk(tag, try_start, e_start, "try_start");
        chk(tag, dshift_evt, e_evt, "dshift_evt");
        chk("R9", dshift_irq, e_irq, "dshift_irq");
    endtask

    initial begin
        m_idle = 1; m_up = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        chk("R1", spd_sel, 2, "spd_sel");
        chk("R1", try_start, 0, "try_start");
        chk("R1", dshift_evt, 0, "dshift_evt");
        chk("R1", dshift_irq, 0, "dshift_irq");
        rst_n = 1'b1;
        step(1, 0, 0, 0, 1);          // R2: idle -> gigabit attempt
        step(1, 0, 1, 0, 1);          // R3: gig -> 100
        step(1, 0, 1, 0, 0);          // R3: 100 -> 10, masked
        step(1, 0, 1, 0, 1);          // R4: wrap to gig
        step(1, 0, 0, 0, 1);
        step(1, 0, 1, 0, 1);          // to 100
        step(0, 0, 1, 0, 1);          // R5: back to gig, no event
        step(0, 0, 1, 0, 1);          // R5: gig retry
        step(1, 0, 1, 0, 1);
        step(1, 1, 1, 0, 1);          // R10: link wins at 100
        step(1, 0, 1, 0, 1);          // R11: fail ignored while up
        step(1, 0, 0, 1, 1);          // R7: restart at gig
        step(1, 0, 0, 1, 1);          // R11: lost ignored in attempt
        for (int i = 0; i < 3072; i++) begin
            int v;
            v = (i * 13 + i / 64 + i / 512) % 64;
            // keep failures frequent and links rarer so every state is visited
            step(v[0] | v[5], v[1] & v[2], v[3] | v[4], v[4] ^ v[0], v[2]);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule